// File: doc/BRIEF.md
# Grouped 3x3 Multiply-Accumulate with Pixel Accumulator

This block produces one output-channel pixel value of a 3x3 convolution whose input channels arrive in groups. Each cycle it takes, for every channel of a group, a 3x3 window of signed 8-bit activations and the matching 3x3 window of signed 8-bit weights. It multiplies all taps of all channels in parallel and reduces the products to a single 32-bit sum. The reduction runs in two registered adder-tree stages: one inside each channel, then one across the channels.

The sum then goes into a per-pixel accumulation memory, addressed by the pixel index that travels with the window. On a pixel's first channel group the memory entry is overwritten. On later groups the stored partial sum is read back and added. The read is issued one stage ahead of the write, and the result of the immediately preceding write is forwarded into it, so one pixel can be accepted every cycle even when the same pixel repeats back to back.

Only when the item is flagged as the last group does the block present the full-precision total on its output with a one-cycle valid pulse, three clock cycles after the item was accepted. Downstream scaling, activation and pooling are left to other blocks.

Top module: `mac3_group_acc`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0.
- R2: For an item flagged both first and last, `out_sum` equals the signed sum over all 8 channels and 9 taps of activation times weight. Channel c, tap t occupies bits [(c*9+t)*8 +: 8] of `in_act` and of `in_wgt`.
- R3: An item with `in_first`=1 discards whatever was stored for its pixel, so a pixel reused after an earlier completed accumulation starts from zero.
- R4: An item with `in_first`=0 adds its channel-group sum to the value stored for its pixel.
- R5: `out_valid` rises only for items accepted with `in_valid`=1 and `in_last`=1. Items without the last flag produce no output.
- R6: A result appears exactly 3 cycles after its item is accepted, and `out_pix` carries that item's pixel index.
- R7: Items for the same pixel on consecutive cycles accumulate correctly, with no lost or stale partial sum.
- R8: Accumulations for different pixels that are interleaved cycle by cycle do not disturb each other.
- R9: Extreme operands (all -128 times -128 over several groups) are summed without overflow in the 32-bit result.
- R10: Cycles with `in_valid`=0 produce no output and leave stored partial sums unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window, weights and tags are valid this cycle |
| in_act | input | 576 | Activation windows, 8 channels x 9 taps x 8 bits, signed |
| in_wgt | input | 576 | Weight windows, same layout as `in_act`, signed |
| in_pix | input | 6 | Output pixel index that addresses the accumulation memory |
| in_first | input | 1 | First channel group of this pixel: overwrite |
| in_last | input | 1 | Last channel group of this pixel: emit result |
| out_valid | output | 1 | One-cycle pulse, a finished pixel total is present |
| out_pix | output | 6 | Pixel index of the finished total |
| out_sum | output | 32 | Signed accumulated total |

## Verification
A corrupted partial sum in the accumulation memory does not show at the ports until that pixel's last group comes out. So the bench scores every finished total against a reference accumulator with long multi-group chains, interleaved pixels and back-to-back repeats of one pixel. A broken forwarding path or a wrong first-group choice then surfaces as a wrong `out_sum` at most three cycles after the last group is accepted. A pipeline tag that slips shows at once as a wrong `out_pix`, a wrong arrival cycle, or an output that appears for an item without the last flag.

// File: rtl/mac3_pkg.sv
package mac3_pkg;

    localparam int CH    = 8;
    localparam int TAPS  = 9;
    localparam int DW    = 8;
    localparam int SW    = 32;
    localparam int PIX   = 64;
    localparam int AW    = $clog2(PIX);
    localparam int VECW  = CH * TAPS * DW;
    localparam int PMAX  = 1 << (2 * DW - 2);

    typedef logic signed [SW-1:0] sum_t;

    typedef struct packed {
        logic          valid;
        logic          first;
        logic          last;
        logic [AW-1:0] pix;
    } tag_t;

    function automatic sum_t smul(input logic signed [DW-1:0] a,
                                  input logic signed [DW-1:0] b);
        sum_t ea;
        sum_t eb;
        ea = sum_t'(a);
        eb = sum_t'(b);
        return ea * eb;
    endfunction

endpackage

// File: rtl/mac3_lane.sv
module mac3_lane
    import mac3_pkg::*;
#(
    parameter int NTAP = TAPS,
    parameter int BITS = DW
) (
    input  logic [NTAP*BITS-1:0] act,
    input  logic [NTAP*BITS-1:0] wgt,
    output sum_t                 dot
);
    localparam int BOUND = NTAP * (1 << (2 * BITS - 2));

    sum_t prod [NTAP];

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign prod[t] = smul(act[t*BITS +: BITS], wgt[t*BITS +: BITS]);
    end

    always_comb begin
        dot = '0;
        for (int t = 0; t < NTAP; t++) begin
            dot = dot + prod[t];
        end
    end

    // R9: a channel dot product never leaves the range its operands allow
    always_comb begin
        a_r9_lane_range: assert (dot <= sum_t'(BOUND) && dot >= -sum_t'(BOUND))
            else $error("lane sum out of range");
    end

endmodule

// File: rtl/mac3_reduce.sv
module mac3_reduce
    import mac3_pkg::*;
#(
    parameter int NCH = CH
) (
    input  logic clk,
    input  logic rst,
    input  sum_t ch_dot [NCH],
    input  tag_t in_tag,
    output sum_t red_sum,
    output tag_t red_tag
);
    sum_t total;

    always_comb begin
        total = '0;
        for (int c = 0; c < NCH; c++) begin
            total = total + ch_dot[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            red_tag <= '0;
            red_sum <= '0;
        end else begin
            red_tag <= in_tag;
            red_sum <= total;
        end
    end

endmodule

// File: rtl/mac3_accum.sv
module mac3_accum
    import mac3_pkg::*;
#(
    parameter int DEPTH = PIX,
    parameter int ABITS = AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ABITS-1:0] rd_pix,
    input  sum_t             grp_sum,
    input  tag_t             grp_tag,
    output logic             out_valid,
    output logic [ABITS-1:0] out_pix,
    output sum_t             out_sum
);
    sum_t mem [DEPTH];
    sum_t rd_q;
    sum_t acc_next;
    logic wr_en;
    logic done;

    assign wr_en    = grp_tag.valid;
    assign done     = grp_tag.valid && grp_tag.last;
    assign acc_next = grp_tag.first ? grp_sum : rd_q + grp_sum;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[grp_tag.pix] <= acc_next;
        end
        if (wr_en && grp_tag.pix == rd_pix) begin
            rd_q <= acc_next;
        end else begin
            rd_q <= mem[rd_pix];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_sum   <= '0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_pix <= grp_tag.pix;
                out_sum <= acc_next;
            end
        end
    end

    // R5: no finished total unless the group in the write stage was the last one
    a_r5_last_only: assert property (@(posedge clk) disable iff (rst)
        !(grp_tag.valid && grp_tag.last) |=> !out_valid)
        else $error("output without last group");

endmodule

// File: rtl/mac3_group_acc.sv
module mac3_group_acc
    import mac3_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [VECW-1:0] in_act,
    input  logic [VECW-1:0] in_wgt,
    input  logic [AW-1:0]   in_pix,
    input  logic            in_first,
    input  logic            in_last,
    output logic            out_valid,
    output logic [AW-1:0]   out_pix,
    output logic [SW-1:0]   out_sum
);
    localparam int CHW = TAPS * DW;

    sum_t lane_dot [CH];
    sum_t s1_dot   [CH];
    tag_t s1_tag;
    sum_t s2_sum;
    tag_t s2_tag;
    sum_t acc_sum;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        mac3_lane #(.NTAP(TAPS), .BITS(DW)) u_lane (
            .act (in_act[c*CHW +: CHW]),
            .wgt (in_wgt[c*CHW +: CHW]),
            .dot (lane_dot[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_tag <= '0;
            for (int c = 0; c < CH; c++) s1_dot[c] <= '0;
        end else begin
            s1_tag <= '{valid: in_valid, first: in_first, last: in_last, pix: in_pix};
            for (int c = 0; c < CH; c++) s1_dot[c] <= lane_dot[c];
        end
    end

    mac3_reduce #(.NCH(CH)) u_red (
        .clk     (clk),
        .rst     (rst),
        .ch_dot  (s1_dot),
        .in_tag  (s1_tag),
        .red_sum (s2_sum),
        .red_tag (s2_tag)
    );

    mac3_accum #(.DEPTH(PIX), .ABITS(AW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .rd_pix    (s1_tag.pix),
        .grp_sum   (s2_sum),
        .grp_tag   (s2_tag),
        .out_valid (out_valid),
        .out_pix   (out_pix),
        .out_sum   (acc_sum)
    );

    assign out_sum = acc_sum;

    // R10: an idle input cycle yields no output three cycles later
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid)
        else $error("output from idle cycle");

    // R6: the finished pixel index is the one accepted three cycles earlier
    a_r6_pix_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_pix == $past(in_pix, 3))
        else $error("pixel index mismatch");

endmodule

// File: tb/mac3_group_acc_bench.sv
module mac3_group_acc_bench;
    import mac3_pkg::*;

    typedef struct {
        int    pix;
        int    sum;
        int    cyc;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [VECW-1:0] in_act = '0;
    logic [VECW-1:0] in_wgt = '0;
    logic [AW-1:0]   in_pix = '0;
    logic            in_first = 1'b0;
    logic            in_last = 1'b0;
    logic            out_valid;
    logic [AW-1:0]   out_pix;
    logic [SW-1:0]   out_sum;

    exp_t q[$];
    int   ref_acc [PIX];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mac3_group_acc u_mac3_group_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_act(in_act), .in_wgt(in_wgt),
        .in_pix(in_pix), .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_pix(out_pix), .out_sum(out_sum)
    );

    function automatic int dot_ref(input logic [VECW-1:0] a, input logic [VECW-1:0] w);
        int s = 0;
        for (int i = 0; i < CH * TAPS; i++) begin
            s += int'($signed(a[i*DW +: DW])) * int'($signed(w[i*DW +: DW]));
        end
        return s;
    endfunction

    function automatic logic [VECW-1:0] rnd_vec();
        logic [VECW-1:0] v;
        for (int i = 0; i < VECW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int pix, input bit first, input bit last,
                        input logic [VECW-1:0] a, input logic [VECW-1:0] w, input string req);
        int d;
        d = dot_ref(a, w);
        if (first) ref_acc[pix] = d;
        else       ref_acc[pix] = ref_acc[pix] + d;
        if (last) q.push_back('{pix: pix, sum: ref_acc[pix], cyc: cyc + 3, req: req});
        in_valid = 1'b1; in_act = a; in_wgt = w;
        in_pix = AW'(pix); in_first = first; in_last = last;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_act = rnd_vec(); in_wgt = rnd_vec(); in_first = 1'b1; in_last = 1'b1;
        repeat (n) @(negedge clk);
        in_first = 1'b0; in_last = 1'b0;
    endtask

    // monitor: pops expected totals as results come out
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R5 unexpected output", int'(out_pix), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(out_pix) == e.pix, {e.req, " R6 pix"}, int'(out_pix), e.pix);
                check(cyc == e.cyc, {e.req, " R6 latency"}, cyc, e.cyc);
                check($signed(out_sum) == e.sum, {e.req, " sum"}, $signed(out_sum), e.sum);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VECW-1:0] a;
        logic [VECW-1:0] w;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 during reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);

        // R2: single-group items
        for (int i = 0; i < 6; i++) send(i, 1, 1, rnd_vec(), rnd_vec(), "R2");
        idle(4);

        // R4: three groups per pixel, pixel after pixel with gaps
        for (int p = 10; p < 14; p++) begin
            send(p, 1, 0, rnd_vec(), rnd_vec(), "R4");
            idle(2);
            send(p, 0, 0, rnd_vec(), rnd_vec(), "R4");
            send(p, 0, 1, rnd_vec(), rnd_vec(), "R4");
        end
        idle(4);

        // R7: same pixel back to back, five groups
        send(20, 1, 0, rnd_vec(), rnd_vec(), "R7");
        for (int g = 0; g < 3; g++) send(20, 0, 0, rnd_vec(), rnd_vec(), "R7");
        send(20, 0, 1, rnd_vec(), rnd_vec(), "R7");
        idle(4);

        // R8: four pixels interleaved cycle by cycle over four groups
        for (int g = 0; g < 4; g++) begin
            for (int p = 30; p < 34; p++) send(p, g == 0, g == 3, rnd_vec(), rnd_vec(), "R8");
        end
        idle(4);

        // R3: pixel 10 reused; its old total must not leak in
        send(10, 1, 1, rnd_vec(), rnd_vec(), "R3");
        send(11, 1, 0, rnd_vec(), rnd_vec(), "R3");
        send(11, 0, 1, rnd_vec(), rnd_vec(), "R3");
        idle(4);

        // R9: extreme operands over three groups -> 3*72*16384
        a = {VECW/DW{8'h80}};
        w = {VECW/DW{8'h80}};
        send(40, 1, 0, a, w, "R9");
        send(40, 0, 0, a, w, "R9");
        send(40, 0, 1, a, w, "R9");
        check(ref_acc[40] == 3538944, "R9 reference", ref_acc[40], 3538944);
        idle(4);

        // R10 and R5: partial groups, then idle cycles carrying random data and flags
        send(50, 1, 0, rnd_vec(), rnd_vec(), "R10");
        send(51, 1, 0, rnd_vec(), rnd_vec(), "R5");
        idle(8);
        check(q.size() == 0, "R5 no output for non-last", q.size(), 0);
        send(50, 0, 1, rnd_vec(), rnd_vec(), "R10");
        send(51, 0, 1, rnd_vec(), rnd_vec(), "R5");
        idle(6);

        check(q.size() == 0, "R5 all results drained", q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule